// File: doc/BRIEF.md
# Turbo Decoder Input Depuncturing Formatter

This block sits in front of a constituent turbo decoder and rebuilds the full-length soft-input frame from a punctured channel stream. The transmitter adds insertion bits that force chosen first-parity bits to zero, and then removes those insertion bits from the air. It also removes the second-encoder parity bits that the insertion bits produce. The formatter walks the frame one index at a time and emits three aligned signed LLR lanes per index: systematic, first parity and second parity. A positive LLR means the bit is zero.

The frame length is the interleaver length Z, which is the information bits plus the insertion bits, so the decoder works over Z indices instead of K. Per index the block goes through its lanes in the fixed order systematic, first parity, second parity:
- A lane that was transmitted takes the next received LLR from a scalar valid/ready input.
- A first-parity lane known to be zero is filled with the most positive LLR.
- Any other removed lane is filled with zero.

The formatter asks the interleaver about the current index through an index output. A flag input answers whether the interleaved bit at that index was an insertion bit.

Top module: `dep_formatter`

## Requirements
- R1: After reset `out_valid` is low, `pos_idx` is 0 and the frame starts at index 0 with the systematic lane.
- R2: An index i is forced when bit (i mod PERIOD) of FORCE_MASK is set (default mask 16'h0919, which is residues 0, 3, 4, 8 and 11) and i < Z - TERM_LEN. For a forced index, `out_p1` is the most positive LLR, 2^(LLR_W-1)-1.
- R3: For a forced index, `out_sys` is 0 and no received LLR is used for that lane.
- R4: `out_p2` is 0 and no LLR is taken for the second-parity lane when `pos_from_ins` is high while `pos_idx` shows that index. The flag is read only while that lane is being formed.
- R5: Every non-punctured lane carries the received LLRs in arrival order: lanes in the order systematic, first parity, second parity within an index, and indices ascending.
- R6: A received LLR is accepted only on a cycle with `in_valid` and `in_ready` both high. `in_ready` is low on every cycle that fills a punctured lane. When a triple is presented, exactly the LLRs its indices need have been accepted.
- R7: Exactly one triple is emitted per index 0..Z-1. `out_last` is high only with index Z-1, after which the next frame restarts at index 0.
- R8: Indices at or above Z - TERM_LEN are never forced, even when their residue matches the mask (for example index 59 with the defaults).
- R9: `out_valid` is a single-cycle strobe and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_llr | input | LLR_W | Received channel LLR, two's complement |
| in_valid | input | 1 | `in_llr` holds a received value |
| in_ready | output | 1 | Block takes `in_llr` this cycle |
| pos_idx | output | IDX_W | Frame index for the interleaver lookup |
| pos_from_ins | input | 1 | Interleaved bit at `pos_idx` is an insertion bit |
| out_sys | output | LLR_W | Systematic LLR for the emitted index |
| out_p1 | output | LLR_W | First-parity LLR for the emitted index |
| out_p2 | output | LLR_W | Second-parity LLR for the emitted index |
| out_valid | output | 1 | Triple strobe |
| out_last | output | 1 | Strobed triple belongs to index Z-1 |

## Verification
The assertions assume that `pos_from_ins` is a pure combinational function of `pos_idx` for the whole frame, and that the received stream contains exactly the lanes the puncturing leaves. The bench derives the flag from a fixed permutation of `pos_idx` and feeds it back in the same cycle. It feeds a counter-generated LLR sequence and advances it only on an accepted handshake, so the stream can neither run ahead of the formatter nor be misaligned with it. Three full frames are swept with different `in_valid` gap patterns. Every index, the termination tail and the frame wrap are all covered.

// File: rtl/dep_pkg.sv
package dep_pkg;
    typedef enum logic [1:0] {
        LANE_SYS = 2'd0,
        LANE_P1  = 2'd1,
        LANE_P2  = 2'd2
    } lane_e;
endpackage

// File: rtl/dep_force_map.sv
module dep_force_map #(
    parameter int          IDX_W  = 6,
    parameter int          PERIOD = 16,
    parameter logic [15:0] MASK   = 16'h0919,
    parameter int          LIMIT  = 58
) (
    input  logic [IDX_W-1:0] idx,
    output logic             forced
);
    localparam int RES_W = $clog2(PERIOD);

    logic [RES_W-1:0]  residue;
    logic [PERIOD-1:0] hit;

    assign residue = idx[RES_W-1:0];

    for (genvar b = 0; b < PERIOD; b++) begin : g_res
        assign hit[b] = MASK[b] && (residue == RES_W'(b));
    end

    assign forced = (|hit) && (32'(idx) < 32'(LIMIT));
endmodule

// File: rtl/dep_lane_fill.sv
module dep_lane_fill
    import dep_pkg::*;
#(
    parameter int LLR_W = 6
) (
    input  lane_e             lane,
    input  logic              forced,
    input  logic              p2_ins,
    output logic              punct,
    output logic [LLR_W-1:0]  fill
);
    localparam logic [LLR_W-1:0] MAX_POS = {1'b0, {(LLR_W-1){1'b1}}};

    always_comb begin
        punct = 1'b0;
        fill  = '0;
        unique case (lane)
            LANE_SYS: punct = forced;
            LANE_P1: begin
                punct = forced;
                fill  = MAX_POS;
            end
            LANE_P2: punct = p2_ins;
            default: punct = 1'b0;
        endcase
    end
endmodule

// File: rtl/dep_formatter.sv
module dep_formatter
    import dep_pkg::*;
#(
    parameter int          LLR_W    = 6,
    parameter int          Z        = 64,
    parameter int          PERIOD   = 16,
    parameter logic [15:0] MASK     = 16'h0919,
    parameter int          TERM_LEN = 6,
    localparam int         IDX_W    = $clog2(Z)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LLR_W-1:0] in_llr,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [IDX_W-1:0] pos_idx,
    input  logic             pos_from_ins,
    output logic [LLR_W-1:0] out_sys,
    output logic [LLR_W-1:0] out_p1,
    output logic [LLR_W-1:0] out_p2,
    output logic             out_valid,
    output logic             out_last
);
    localparam int               LIMIT    = Z - TERM_LEN;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(Z - 1);
    localparam logic [LLR_W-1:0] MAX_POS  = {1'b0, {(LLR_W-1){1'b1}}};

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        lane_e            lane;
        logic [LLR_W-1:0] sys;
        logic [LLR_W-1:0] p1;
        logic             ovalid;
        logic             olast;
        logic [IDX_W-1:0] oidx;
        logic [LLR_W-1:0] osys;
        logic [LLR_W-1:0] op1;
        logic [LLR_W-1:0] op2;
    } state_t;

    state_t s_d, s_q;

    logic             cur_forced;
    logic             out_forced;
    logic             punct;
    logic [LLR_W-1:0] fill;

    dep_force_map #(
        .IDX_W(IDX_W), .PERIOD(PERIOD), .MASK(MASK), .LIMIT(LIMIT)
    ) u_map_cur (
        .idx(s_q.idx), .forced(cur_forced)
    );

    dep_force_map #(
        .IDX_W(IDX_W), .PERIOD(PERIOD), .MASK(MASK), .LIMIT(LIMIT)
    ) u_map_out (
        .idx(s_q.oidx), .forced(out_forced)
    );

    dep_lane_fill #(.LLR_W(LLR_W)) u_fill (
        .lane(s_q.lane), .forced(cur_forced), .p2_ins(pos_from_ins),
        .punct(punct), .fill(fill)
    );

    always_comb begin
        logic             take;
        logic [LLR_W-1:0] val;
        s_d        = s_q;
        s_d.ovalid = 1'b0;
        s_d.olast  = 1'b0;
        take       = punct || in_valid;
        val        = punct ? fill : in_llr;
        if (take) begin
            unique case (s_q.lane)
                LANE_SYS: begin
                    s_d.sys  = val;
                    s_d.lane = LANE_P1;
                end
                LANE_P1: begin
                    s_d.p1   = val;
                    s_d.lane = LANE_P2;
                end
                LANE_P2: begin
                    s_d.ovalid = 1'b1;
                    s_d.olast  = (s_q.idx == LAST_IDX);
                    s_d.oidx   = s_q.idx;
                    s_d.osys   = s_q.sys;
                    s_d.op1    = s_q.p1;
                    s_d.op2    = val;
                    s_d.idx    = (s_q.idx == LAST_IDX) ? '0 : s_q.idx + 1'b1;
                    s_d.lane   = LANE_SYS;
                end
                default: s_d.lane = LANE_SYS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.lane <= LANE_SYS;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = !punct;
    assign pos_idx   = s_q.idx;
    assign out_sys   = s_q.osys;
    assign out_p1    = s_q.op1;
    assign out_p2    = s_q.op2;
    assign out_valid = s_q.ovalid;
    assign out_last  = s_q.olast;

    AST_FORCED_P1_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_forced |-> out_p1 == MAX_POS); // R2
    AST_FORCED_SYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_forced |-> out_sys == '0); // R3
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R9
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> pos_idx == '0); // R7
endmodule

// File: tb/dep_formatter_bench.sv
module dep_formatter_bench;
    localparam int Z = 64;
    localparam int W = 6;
    localparam int TERM = 6;
    localparam int FRAMES = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_llr = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [5:0]   pos_idx;
    logic         pos_from_ins;
    logic [W-1:0] out_sys, out_p1, out_p2;
    logic         out_valid, out_last;

    int n_chk = 0, n_bad = 0;
    int kin = 0, exp_k = 0, n_out = 0, cyc = 0;

    always #2.5 clk = ~clk;

    dep_formatter u_dep_formatter (
        .clk(clk), .rst_n(rst_n), .in_llr(in_llr), .in_valid(in_valid),
        .in_ready(in_ready), .pos_idx(pos_idx), .pos_from_ins(pos_from_ins),
        .out_sys(out_sys), .out_p1(out_p1), .out_p2(out_p2),
        .out_valid(out_valid), .out_last(out_last)
    );

    function automatic bit fz(int i);
        int r = i % 16;
        return (r == 0 || r == 3 || r == 4 || r == 8 || r == 11) && (i < Z - TERM);
    endfunction

    function automatic bit ins_flag(int i);
        return fz((i * 13 + 5) % Z);
    endfunction

    function automatic logic [W-1:0] rx(int k);
        return W'(((k * 7 + 3) % 61) - 30);
    endfunction

    always_comb pos_from_ins = ins_flag(int'(pos_idx));

    task automatic check(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && in_valid && in_ready) kin <= kin + 1;
    end

    always @(negedge clk) begin
        int fr;
        fr = n_out / Z;
        if (!rst_n) in_valid = 1'b0;
        else if (fr == 0) in_valid = (cyc % 5) != 2;
        else if (fr == 1) in_valid = 1'b1;
        else in_valid = (cyc % 3) != 0;
        in_llr = rx(kin);
    end

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            int e;
            logic [W-1:0] es, e1, e2;
            e = n_out % Z;
            if (fz(e)) begin
                es = '0;
                e1 = 6'd31;
            end else begin
                es = rx(exp_k);
                e1 = rx(exp_k + 1);
                exp_k += 2;
            end
            if (ins_flag(e)) e2 = '0;
            else begin
                e2 = rx(exp_k);
                exp_k++;
            end
            // R2, R3, R8 on forced and tail indices
            check(fz(e) ? "R3 sys" : (e >= Z - TERM ? "R8 sys" : "R5 sys"),
                  int'(out_sys), int'(es));
            check(fz(e) ? "R2 p1" : (e >= Z - TERM ? "R8 p1" : "R5 p1"),
                  int'(out_p1), int'(e1));
            check(ins_flag(e) ? "R4 p2" : "R5 p2", int'(out_p2), int'(e2));
            check("R7 last", int'(out_last), int'(e == Z - 1));
            check("R6 consumed", kin, exp_k);
            n_out++;
        end
    end

    logic prev_v = 1'b0;
    always @(negedge clk) begin
        if (rst_n && prev_v && out_valid) check("R9 strobe", 1, 0);
        prev_v = out_valid;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 pos_idx", int'(pos_idx), 0);
        check("R6 ready on forced idx0", int'(in_ready), 0);
        @(negedge clk);
        rst_n = 1'b1;
        while (n_out < FRAMES * Z && cyc < 20000) @(negedge clk);
        if (cyc >= 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", n_out, FRAMES * Z);
        end
        @(negedge clk);
        check("R7 wrap index", int'(pos_idx), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule